// File: doc/BRIEF.md
# Hybrid Directory Copy Tracker

This block sits beside the tag array of a shared last-level cache. For each of a small number of cache lines, it records which private L1 caches hold a copy. While a line has few sharers, the block stores an exact list. Each list slot holds the sharer's source identifier and a flag that says whether the copy is an instruction copy or a data copy. When a line gains more sharers than a threshold allows, the list is discarded and the block keeps only a count of copies.

Requests arrive one at a time on a single request port with a valid/ready handshake. There are four operations:
- **register**: a new copy was handed out.
- **cleanup**: an L1 dropped its copy.
- **write**: the line was written.
- **evict**: the line is being replaced.

For a write or an evict, the block produces a stream of coherence actions, one per cycle. In list mode these are targeted updates or targeted invalidates, each naming one sharer. In count mode the block produces a single broadcast invalidate.

The control is a three-state machine:
- **IDLE** accepts requests. Register and cleanup complete in IDLE.
- **WALK** visits one list slot per cycle.
- **BCAST** emits the one broadcast cycle.

The transitions are:
- **start_walk**: IDLE to WALK, on a write or evict to a list-mode line.
- **start_bcast**: IDLE to BCAST, on a write or evict to a count-mode line.
- **walk_done**: WALK to IDLE, after the last slot.
- **bcast_done**: BCAST to IDLE, after one cycle.

Top module: `sharer_tracker`

## Requirements
- R1: After reset, every line is in list mode with an empty list and count zero. `req_ready` is 1, `act_valid` is 0 and `cln_err` is 0.
- R2: A register (`req_op`=0) to a list-mode line that has a free slot stores the pair (`req_src`, `req_inst`) in the lowest-numbered free slot and adds one to the count. If the pair is already present, the line is unchanged. The same source with different `req_inst` values occupies two slots.
- R3: A register of a new pair to a list-mode line whose list already holds THRESH entries flushes the list. The line enters count mode with count THRESH+1.
- R4: A register to a count-mode line adds one to the count, saturating at 2^(SRC_W+2)-1.
- R5: A write (`req_op`=2) to a list-mode line emits one update action (`act_kind`=1) per occupied slot, in ascending slot order. The only slot skipped is one holding the writer's `req_src` with `act_inst`=0 (data copy). The writer's instruction copy is still updated.
- R6: An evict (`req_op`=3) to a list-mode line emits one invalidate action (`act_kind`=2) per occupied slot, in ascending slot order.
- R7: A write or an evict to a count-mode line emits exactly one action cycle, with `act_kind`=3 (broadcast invalidate).
- R8: A cleanup (`req_op`=1) to a list-mode line frees the slot holding the matching pair and subtracts one from the count. If no slot matches, `cln_err` is 1 for the one cycle after acceptance and the line is unchanged.
- R9: A cleanup to a count-mode line subtracts one from the count. When the count reaches zero, the line returns to list mode with an empty list.
- R10: Register and cleanup are accepted in one cycle and `req_ready` stays 1.
- R11: A write or evict holds `req_ready` at 0 for THRESH cycles in list mode, or for 1 cycle in count mode. Actions appear only during those cycles, starting in the cycle after acceptance, and never while `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 register, 1 cleanup, 2 write, 3 evict |
| req_line | input | $clog2(NUM_LINES) | Tracked line index |
| req_src | input | SRC_W | L1 source identifier (for a write: the writer) |
| req_inst | input | 1 | 1 instruction copy, 0 data copy |
| req_ready | output | 1 | Block is idle and accepts a request |
| act_valid | output | 1 | Coherence action valid this cycle |
| act_kind | output | 2 | 1 update, 2 invalidate, 3 broadcast invalidate |
| act_src | output | SRC_W | Target source identifier (targeted actions) |
| act_inst | output | 1 | Target copy type (targeted actions) |
| cln_err | output | 1 | Cleanup matched no list entry |

## Verification
The bench builds the block with the following parameters:

| Parameter | Value |
|---|---|
| THRESH | 3 |
| NUM_LINES | 4 |
| SRC_W | 3 |

With only eight sources and four lines, random traffic crosses the list-to-count boundary often. It also reaches duplicate registrations and unmatched cleanups on its own. The 5-bit count saturates at 31 after a short directed run of registrations, and the same line is then drained back to an empty list with cleanups. That run covers both the saturation edge and the return from count mode.

// File: rtl/tracker_pkg.sv
package tracker_pkg;

    typedef enum logic [1:0] {
        OP_REG     = 2'd0,
        OP_CLEANUP = 2'd1,
        OP_WRITE   = 2'd2,
        OP_EVICT   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_UPDATE = 2'd1,
        ACT_INVAL  = 2'd2,
        ACT_BCAST  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_BCAST = 2'd2
    } walk_st_e;

endpackage

// File: rtl/tracker_store.sv
module tracker_store #(
    parameter int NUM_LINES = 4,
    parameter int SRC_W     = 4,
    parameter int THRESH    = 4,
    localparam int LINE_W   = $clog2(NUM_LINES),
    localparam int IDX_W    = $clog2(THRESH),
    localparam int CNT_W    = SRC_W + 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           upd_en,
    input  logic                           upd_cleanup,
    input  logic [LINE_W-1:0]              upd_line,
    input  logic [SRC_W-1:0]               upd_src,
    input  logic                           upd_inst,
    output logic                           err,
    input  logic [LINE_W-1:0]              rd_line,
    output logic                           rd_ctr_mode,
    output logic [THRESH-1:0]              rd_valid,
    output logic [THRESH-1:0][SRC_W-1:0]   rd_src,
    output logic [THRESH-1:0]              rd_inst
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic                         ctr_mode [NUM_LINES];
    logic [CNT_W-1:0]             cnt      [NUM_LINES];
    logic [THRESH-1:0]            vld      [NUM_LINES];
    logic [THRESH-1:0][SRC_W-1:0] src_q    [NUM_LINES];
    logic [THRESH-1:0]            inst_q   [NUM_LINES];

    logic             hit_any, free_any;
    logic [IDX_W-1:0] hit_idx, free_idx;

    // Lowest matching slot and lowest free slot of the addressed line
    always_comb begin
        hit_any  = 1'b0;
        free_any = 1'b0;
        hit_idx  = '0;
        free_idx = '0;
        for (int i = THRESH - 1; i >= 0; i--) begin
            if (vld[upd_line][i] && src_q[upd_line][i] == upd_src &&
                inst_q[upd_line][i] == upd_inst) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!vld[upd_line][i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
            for (int l = 0; l < NUM_LINES; l++) begin
                ctr_mode[l] <= 1'b0;
                cnt[l]      <= '0;
                vld[l]      <= '0;
                src_q[l]    <= '0;
                inst_q[l]   <= '0;
            end
        end else begin
            err <= 1'b0;
            if (upd_en) begin
                if (!upd_cleanup) begin
                    if (ctr_mode[upd_line]) begin
                        if (cnt[upd_line] != CNT_MAX)
                            cnt[upd_line] <= cnt[upd_line] + 1'b1;
                    end else if (!hit_any) begin
                        if (free_any) begin
                            vld[upd_line][free_idx]    <= 1'b1;
                            src_q[upd_line][free_idx]  <= upd_src;
                            inst_q[upd_line][free_idx] <= upd_inst;
                        end else begin
                            vld[upd_line]      <= '0;
                            ctr_mode[upd_line] <= 1'b1;
                        end
                        cnt[upd_line] <= cnt[upd_line] + 1'b1;
                    end
                end else begin
                    if (ctr_mode[upd_line]) begin
                        cnt[upd_line] <= cnt[upd_line] - 1'b1;
                        if (cnt[upd_line] == CNT_W'(1))
                            ctr_mode[upd_line] <= 1'b0;
                    end else if (hit_any) begin
                        vld[upd_line][hit_idx] <= 1'b0;
                        cnt[upd_line]          <= cnt[upd_line] - 1'b1;
                    end else begin
                        err <= 1'b1;
                    end
                end
            end
        end
    end

    assign rd_ctr_mode = ctr_mode[rd_line];
    assign rd_valid    = vld[rd_line];
    assign rd_src      = src_q[rd_line];
    assign rd_inst     = inst_q[rd_line];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line_chk
        // R2 R3: list-mode count always equals occupied slots
        a_r2_list_count: assert property (@(posedge clk) disable iff (!rst_n)
            !ctr_mode[g] |-> $countones(vld[g]) == int'(cnt[g]));
        // R9: count mode holds no locations and a nonzero count
        a_r9_ctr_empty: assert property (@(posedge clk) disable iff (!rst_n)
            ctr_mode[g] |-> (vld[g] == '0 && cnt[g] != '0));
    end

    // R8: an error pulse only follows an accepted cleanup
    a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(upd_en && upd_cleanup));

endmodule

// File: rtl/tracker_walker.sv
module tracker_walker
    import tracker_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int SRC_W     = 4,
    parameter int THRESH    = 4,
    localparam int LINE_W   = $clog2(NUM_LINES),
    localparam int IDX_W    = $clog2(THRESH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         start_write,
    input  logic [LINE_W-1:0]            start_line,
    input  logic [SRC_W-1:0]             start_src,
    input  logic                         ctr_mode,
    input  logic [THRESH-1:0]            rd_valid,
    input  logic [THRESH-1:0][SRC_W-1:0] rd_src,
    input  logic [THRESH-1:0]            rd_inst,
    output logic [LINE_W-1:0]            rd_line,
    output logic                         idle,
    output logic                         act_valid,
    output logic [1:0]                   act_kind,
    output logic [SRC_W-1:0]             act_src,
    output logic                         act_inst
);

    walk_st_e          state, state_nx;
    logic [IDX_W-1:0]  idx;
    logic [LINE_W-1:0] line_q;
    logic [SRC_W-1:0]  writer_q;
    logic              write_q;
    logic              skip;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ctr_mode ? ST_BCAST : ST_WALK;
            ST_WALK:  if (idx == IDX_W'(THRESH - 1)) state_nx = ST_IDLE;
            ST_BCAST: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            line_q   <= '0;
            writer_q <= '0;
            write_q  <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                idx      <= '0;
                line_q   <= start_line;
                writer_q <= start_src;
                write_q  <= start_write;
            end else if (state == ST_WALK) begin
                idx <= idx + 1'b1;
            end
        end
    end

    assign rd_line = (state == ST_IDLE) ? start_line : line_q;
    assign skip    = write_q && rd_src[idx] == writer_q && !rd_inst[idx];

    always_comb begin
        idle      = 1'b0;
        act_valid = 1'b0;
        act_kind  = ACT_NONE;
        act_src   = '0;
        act_inst  = 1'b0;
        unique case (state)
            ST_IDLE: idle = 1'b1;
            ST_WALK: begin
                act_valid = rd_valid[idx] && !skip;
                act_kind  = write_q ? ACT_UPDATE : ACT_INVAL;
                act_src   = rd_src[idx];
                act_inst  = rd_inst[idx];
            end
            ST_BCAST: begin
                act_valid = 1'b1;
                act_kind  = ACT_BCAST;
            end
            default: idle = 1'b1;
        endcase
    end

    // R7: broadcast occupies a single cycle
    a_r7_bcast_once: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_BCAST |=> state == ST_IDLE);
    // R11: a walk never begins mid-slot
    a_r11_walk_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_WALK) |-> idx == '0);

endmodule

// File: rtl/sharer_tracker.sv
module sharer_tracker
    import tracker_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int SRC_W     = 4,
    parameter int THRESH    = 4,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [LINE_W-1:0] req_line,
    input  logic [SRC_W-1:0]  req_src,
    input  logic              req_inst,
    output logic              req_ready,
    output logic              act_valid,
    output logic [1:0]        act_kind,
    output logic [SRC_W-1:0]  act_src,
    output logic              act_inst,
    output logic              cln_err
);

    logic                         accept, upd_en, start;
    logic [LINE_W-1:0]            rd_line;
    logic                         rd_ctr_mode;
    logic [THRESH-1:0]            rd_valid;
    logic [THRESH-1:0][SRC_W-1:0] rd_src;
    logic [THRESH-1:0]            rd_inst;

    assign accept = req_valid && req_ready;
    assign upd_en = accept && (req_op == OP_REG || req_op == OP_CLEANUP);
    assign start  = accept && (req_op == OP_WRITE || req_op == OP_EVICT);

    tracker_store #(.NUM_LINES(NUM_LINES), .SRC_W(SRC_W), .THRESH(THRESH)) store_i (
        .clk(clk), .rst_n(rst_n),
        .upd_en(upd_en), .upd_cleanup(req_op == OP_CLEANUP),
        .upd_line(req_line), .upd_src(req_src), .upd_inst(req_inst),
        .err(cln_err),
        .rd_line(rd_line), .rd_ctr_mode(rd_ctr_mode),
        .rd_valid(rd_valid), .rd_src(rd_src), .rd_inst(rd_inst)
    );

    tracker_walker #(.NUM_LINES(NUM_LINES), .SRC_W(SRC_W), .THRESH(THRESH)) walker_i (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_write(req_op == OP_WRITE),
        .start_line(req_line), .start_src(req_src),
        .ctr_mode(rd_ctr_mode), .rd_valid(rd_valid), .rd_src(rd_src), .rd_inst(rd_inst),
        .rd_line(rd_line), .idle(req_ready),
        .act_valid(act_valid), .act_kind(act_kind), .act_src(act_src), .act_inst(act_inst)
    );

    // R11: no action while the block accepts requests
    a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !act_valid);
    // R10: register and cleanup leave the block ready
    a_r10_upd_ready: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> req_ready);

endmodule

// File: tb/sharer_tracker_tb_top.sv
module sharer_tracker_tb_top;

    localparam int LINES = 4;
    localparam int SW    = 3;
    localparam int TH    = 3;
    localparam int CMAX  = (1 << (SW + 2)) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [1:0]    req_line = '0;
    logic [SW-1:0] req_src = '0;
    logic          req_inst = 1'b0;
    logic          req_ready, act_valid, act_inst, cln_err;
    logic [1:0]    act_kind;
    logic [SW-1:0] act_src;

    always #10 clk = ~clk;

    sharer_tracker #(.NUM_LINES(LINES), .SRC_W(SW), .THRESH(TH)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_line(req_line), .req_src(req_src), .req_inst(req_inst),
        .req_ready(req_ready), .act_valid(act_valid), .act_kind(act_kind),
        .act_src(act_src), .act_inst(act_inst), .cln_err(cln_err)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // Reference model
    bit m_ctr  [LINES];
    int m_cnt  [LINES];
    bit m_v    [LINES][TH];
    int m_src  [LINES][TH];
    bit m_inst [LINES][TH];

    int  e_n, e_busy;
    bit  e_err;
    int  e_kind [TH];
    int  e_src  [TH];
    bit  e_inst [TH];

    function automatic int find_hit(int l, int s, bit ins);
        for (int i = 0; i < TH; i++)
            if (m_v[l][i] && m_src[l][i] == s && m_inst[l][i] == ins) return i;
        return -1;
    endfunction

    function automatic int find_free(int l);
        for (int i = 0; i < TH; i++) if (!m_v[l][i]) return i;
        return -1;
    endfunction

    // Expected outcome computed from pre-request model state
    function automatic void predict(int op, int l, int s, bit ins);
        e_n = 0; e_err = 1'b0; e_busy = 0;
        if (op == 1 && !m_ctr[l] && find_hit(l, s, ins) < 0) e_err = 1'b1;
        if (op >= 2) begin
            if (m_ctr[l]) begin
                e_busy = 1; e_kind[0] = 3; e_src[0] = 0; e_inst[0] = 0; e_n = 1;
            end else begin
                e_busy = TH;
                for (int i = 0; i < TH; i++)
                    if (m_v[l][i] && !(op == 2 && m_src[l][i] == s && !m_inst[l][i])) begin
                        e_kind[e_n] = (op == 2) ? 1 : 2;
                        e_src[e_n]  = m_src[l][i];
                        e_inst[e_n] = m_inst[l][i];
                        e_n++;
                    end
            end
        end
    endfunction

    function automatic void model_update(int op, int l, int s, bit ins);
        int h, f;
        h = find_hit(l, s, ins);
        f = find_free(l);
        if (op == 0) begin
            if (m_ctr[l]) begin
                if (m_cnt[l] < CMAX) m_cnt[l]++;
            end else if (h < 0) begin
                if (f >= 0) begin
                    m_v[l][f] = 1'b1; m_src[l][f] = s; m_inst[l][f] = ins;
                end else begin
                    for (int i = 0; i < TH; i++) m_v[l][i] = 1'b0;
                    m_ctr[l] = 1'b1;
                end
                m_cnt[l]++;
            end
        end else if (op == 1) begin
            if (m_ctr[l]) begin
                m_cnt[l]--;
                if (m_cnt[l] == 0) m_ctr[l] = 1'b0;
            end else if (h >= 0) begin
                m_v[l][h] = 1'b0; m_cnt[l]--;
            end
        end
    endfunction

    function automatic string req_tag(int op);
        if (op == 0) return "R2/R3/R4";
        if (op == 1) return "R8/R9";
        if (op == 2) return "R5/R7";
        return "R6/R7";
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_req(int op, int l, int s, bit ins);
        int got_n, busy;
        int g_kind [TH + 1];
        int g_src  [TH + 1];
        bit g_inst [TH + 1];
        bit first, err_seen;
        predict(op, l, s, ins);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_line = 2'(l);
        req_src = SW'(s); req_inst = ins;
        @(posedge clk);
        #1 req_valid = 1'b0;
        got_n = 0; busy = 0; first = 1'b1; err_seen = 1'b0;
        forever begin
            @(negedge clk);
            if (first) err_seen = cln_err;
            first = 1'b0;
            if (req_ready) begin
                if (act_valid) got_n = 99; // R11 action while idle
                break;
            end
            busy++;
            if (act_valid && got_n <= TH) begin
                g_kind[got_n] = act_kind; g_src[got_n] = act_src; g_inst[got_n] = act_inst;
                got_n++;
            end
            if (busy > TH + 2) break;
        end
        check(err_seen == e_err, "R8 cln_err", err_seen, e_err);
        check(busy == e_busy, "R10/R11 busy cycles", busy, e_busy);
        check(got_n == e_n, {req_tag(op), " action count"}, got_n, e_n);
        if (got_n == e_n)
            for (int i = 0; i < e_n; i++) begin
                check(g_kind[i] == e_kind[i], {req_tag(op), " act_kind"}, g_kind[i], e_kind[i]);
                if (e_kind[i] != 3) begin
                    check(g_src[i] == e_src[i], {req_tag(op), " act_src"}, g_src[i], e_src[i]);
                    check(g_inst[i] == e_inst[i], {req_tag(op), " act_inst"}, g_inst[i], e_inst[i]);
                end
            end
        model_update(op, l, s, ins);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int l = 0; l < LINES; l++) begin
            m_ctr[l] = 1'b0; m_cnt[l] = 0;
            for (int i = 0; i < TH; i++) begin
                m_v[l][i] = 1'b0; m_src[l][i] = 0; m_inst[l][i] = 1'b0;
            end
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        check(act_valid == 1'b0, "R1 act_valid", act_valid, 0);
        check(cln_err == 1'b0, "R1 cln_err", cln_err, 0);
        for (int l = 0; l < LINES; l++) do_req(3, l, 0, 0); // R1: empty lists

        // R2: same core, both copy types, plus duplicate
        do_req(0, 0, 5, 0);
        do_req(0, 0, 5, 1);
        do_req(0, 0, 5, 1);
        do_req(2, 0, 5, 0);       // R5: writer data copy skipped, instr kept
        do_req(1, 0, 5, 0);       // R8 removal
        do_req(1, 0, 6, 0);       // R8 unmatched -> error
        do_req(6 - 4, 0, 2, 0);   // R5 write by other core
        do_req(0, 0, 2, 0);       // R2 lowest free slot reuse
        do_req(0, 0, 3, 0);
        do_req(3, 0, 0, 0);       // R6 ordering
        do_req(0, 0, 4, 1);       // R3 overflow to count mode
        do_req(2, 0, 1, 0);       // R7 write broadcast
        do_req(3, 0, 1, 0);       // R7 evict broadcast
        for (int k = 0; k < 4; k++) do_req(1, 0, 0, 0); // R9 drain to zero
        do_req(2, 0, 1, 0);       // R9 back to empty list

        // R4: saturation on line 3, then drain
        for (int k = 0; k < 34; k++) do_req(0, 3, k % 8, k[3]);
        for (int k = 0; k < CMAX - 1; k++) do_req(1, 3, 0, 0);
        do_req(3, 3, 0, 0);       // R4 one copy left -> broadcast
        do_req(1, 3, 0, 0);
        do_req(3, 3, 0, 0);       // R9 list again, empty

        // Constrained random traffic
        for (int k = 0; k < 1500; k++) begin
            int r, op, l, s;
            bit ins;
            r = $urandom % 100;
            op = (r < 48) ? 0 : (r < 76) ? 1 : (r < 88) ? 2 : 3;
            l = $urandom % LINES;
            s = $urandom % 8;
            ins = 1'($urandom % 2);
            if (op == 1 && !m_ctr[l] && ($urandom % 10) < 8) begin
                int j;
                j = $urandom % TH;
                if (m_v[l][j]) begin s = m_src[l][j]; ins = m_inst[l][j]; end
            end
            do_req(op, l, s, ins);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule